// File: doc/BRIEF.md
# Debug Mailbox Channel

This block gives a processor core and an external debugger two one-word mailboxes. The two sides run on unrelated clocks. One mailbox carries words from the core to the debugger, and a send flag (W) guards it. The other carries words from the debugger to the core, and a receive flag (R) guards it. Each flag is set from one clock domain and cleared from the other. A set or clear request crosses as a level toggle through a multi-flop synchronizer, so no event is lost, however the two clock rates compare.

Both sides use the same small register port. A one-bit slot select picks either the status word or the data slot. A read strobe and a write strobe act on the chosen slot. Each side sees both flags in its own status word, either as local state or as a synchronized copy. The sender polls for a clear flag and then writes the data slot. The receiver polls for a set flag and then reads the data slot, and that read hands the mailbox back. The debugger port stands in for a scan path that is clocked by the debug clock.

Top module: `dbg_mailbox`

## Requirements
- R1: A core write to the data slot (slot select 1) while W is clear stores the word and shows W=1 in the core status word from the next core clock. W never becomes set without such a write.
- R2: Within SYNC_STAGES+1 debug clocks of a core write, the debugger status word shows W=1. A debugger read of the data slot then returns the stored word and shows W=0 in the debugger status from the next debug clock.
- R3: After the debugger has taken the word, W in the core status word clears within SYNC_STAGES+1 core clocks. Until then, W stays set.
- R4: A core write to the data slot while W is set is ignored, and the debugger later reads the earlier word.
- R5: A debugger write to the data slot while R is clear stores the word and shows R=1 in the debugger status from the next debug clock.
- R6: Within SYNC_STAGES+1 core clocks, the core status shows R=1. A core read of the data slot then returns the word and shows R=0 in the core status from the next core clock.
- R7: After the core has taken the word, R in the debugger status clears within SYNC_STAGES+1 debug clocks.
- R8: A debugger write to the data slot while R is set is ignored, and the core later reads the earlier word.
- R9: The status word (slot select 0) holds W at bit 0 and R at bit 1, and all other bits read as zero. Writes to the status slot have no effect on either side.
- R10: After either reset, every flag view reads clear.
- R11: A read of the data slot while the matching flag is clear changes no flag on either side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| core_clk | input | 1 | Core clock |
| core_rst_n | input | 1 | Core-domain asynchronous active-low reset |
| core_wr_en | input | 1 | Core write strobe |
| core_rd_en | input | 1 | Core read strobe |
| core_addr | input | 1 | Core slot select: 0 status, 1 data |
| core_wdata | input | DATA_W | Core write data |
| core_rdata | output | DATA_W | Core read data (status or incoming word) |
| dbg_clk | input | 1 | Debug clock |
| dbg_rst_n | input | 1 | Debug-domain asynchronous active-low reset |
| dbg_wr_en | input | 1 | Debugger write strobe |
| dbg_rd_en | input | 1 | Debugger read strobe |
| dbg_addr | input | 1 | Debugger slot select: 0 status, 1 data |
| dbg_wdata | input | DATA_W | Debugger write data |
| dbg_rdata | output | DATA_W | Debugger read data (status or outgoing word) |

## Verification
The bench writes to each mailbox while it is still full. A design that let the second write through would deliver the newer word, so the reader would see the wrong value. It also reads data slots that are empty. A design that acknowledged those reads would toggle the handshake and leave a flag set on one side with nothing behind it. Random traffic in both directions runs with a debug clock that has no fixed relation to the core clock. Under that traffic, a toggle lost in the synchronizer would either stall a flag until the watchdog expires or deliver a word twice. The bench also checks the status bit layout and checks that status-slot writes do nothing, so a swapped or leaking bit shows up at once.

// File: rtl/dbgmbox_pkg.sv
package dbgmbox_pkg;
  typedef enum logic {
    SLOT_STATUS = 1'b0,
    SLOT_DATA   = 1'b1
  } slot_e;

  localparam int STAT_W_BIT = 0;
  localparam int STAT_R_BIT = 1;
  localparam int STAT_FLAGS = 2;
endpackage

// File: rtl/mbox_rst_sync.sv
module mbox_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= chain_d;
  end

  assign rst_n_out = chain_q[STAGES-1];
endmodule

// File: rtl/mbox_sync_bit.sv
module mbox_sync_bit #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/mbox_lane.sv
module mbox_lane #(
  parameter int WIDTH       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             prod_clk,
  input  logic             prod_rst_n,
  input  logic             prod_put,
  input  logic [WIDTH-1:0] prod_data,
  output logic             prod_full,
  output logic [WIDTH-1:0] held_word,
  input  logic             cons_clk,
  input  logic             cons_rst_n,
  input  logic             cons_take,
  output logic             cons_full
);
  // producer domain state
  logic             req_q;
  logic             req_d;
  logic             put_ok;
  logic [WIDTH-1:0] word_q;
  logic             ack_seen;
  // consumer domain state
  logic             ack_q;
  logic             ack_d;
  logic             take_ok;
  logic             req_seen;

  always_comb begin
    put_ok = prod_put & ~prod_full;
    req_d  = req_q ^ put_ok;
  end

  always_ff @(posedge prod_clk or negedge prod_rst_n) begin
    if (!prod_rst_n) req_q <= 1'b0;
    else             req_q <= req_d;
  end

  // word is captured on the same edge the request toggles; the request
  // needs SYNC_STAGES consumer edges, so the word is stable when seen
  always_ff @(posedge prod_clk or negedge prod_rst_n) begin
    if (!prod_rst_n)  word_q <= '0;
    else if (put_ok)  word_q <= prod_data;
  end

  mbox_sync_bit #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk   (prod_clk),
    .rst_n (prod_rst_n),
    .d     (ack_q),
    .q     (ack_seen)
  );

  assign prod_full = req_q ^ ack_seen;
  assign held_word = word_q;

  mbox_sync_bit #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk   (cons_clk),
    .rst_n (cons_rst_n),
    .d     (req_q),
    .q     (req_seen)
  );

  assign cons_full = req_seen ^ ack_q;

  always_comb begin
    take_ok = cons_take & cons_full;
    ack_d   = ack_q ^ take_ok;
  end

  always_ff @(posedge cons_clk or negedge cons_rst_n) begin
    if (!cons_rst_n) ack_q <= 1'b0;
    else             ack_q <= ack_d;
  end
endmodule

// File: rtl/dbg_mailbox.sv
module dbg_mailbox
  import dbgmbox_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              core_clk,
  input  logic              core_rst_n,
  input  logic              core_wr_en,
  input  logic              core_rd_en,
  input  logic              core_addr,
  input  logic [DATA_W-1:0] core_wdata,
  output logic [DATA_W-1:0] core_rdata,
  input  logic              dbg_clk,
  input  logic              dbg_rst_n,
  input  logic              dbg_wr_en,
  input  logic              dbg_rd_en,
  input  logic              dbg_addr,
  input  logic [DATA_W-1:0] dbg_wdata,
  output logic [DATA_W-1:0] dbg_rdata
);
  localparam int PAD_W = DATA_W - STAT_FLAGS;

  logic              core_rst_ns;
  logic              dbg_rst_ns;
  logic              core_put, core_take;
  logic              dbg_put,  dbg_take;
  logic              core_w, core_r;
  logic              dbg_w,  dbg_r;
  logic [DATA_W-1:0] c2d_word;
  logic [DATA_W-1:0] d2c_word;
  logic [DATA_W-1:0] core_status;
  logic [DATA_W-1:0] dbg_status;

  mbox_rst_sync #(.STAGES(SYNC_STAGES)) u_core_rst (
    .clk       (core_clk),
    .rst_n_in  (core_rst_n),
    .rst_n_out (core_rst_ns)
  );

  mbox_rst_sync #(.STAGES(SYNC_STAGES)) u_dbg_rst (
    .clk       (dbg_clk),
    .rst_n_in  (dbg_rst_n),
    .rst_n_out (dbg_rst_ns)
  );

  always_comb begin
    core_put  = core_wr_en & (core_addr == SLOT_DATA);
    core_take = core_rd_en & (core_addr == SLOT_DATA);
    dbg_put   = dbg_wr_en  & (dbg_addr  == SLOT_DATA);
    dbg_take  = dbg_rd_en  & (dbg_addr  == SLOT_DATA);
  end

  // core -> debugger lane (W flag)
  mbox_lane #(.WIDTH(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_c2d (
    .prod_clk   (core_clk),
    .prod_rst_n (core_rst_ns),
    .prod_put   (core_put),
    .prod_data  (core_wdata),
    .prod_full  (core_w),
    .held_word  (c2d_word),
    .cons_clk   (dbg_clk),
    .cons_rst_n (dbg_rst_ns),
    .cons_take  (dbg_take),
    .cons_full  (dbg_w)
  );

  // debugger -> core lane (R flag)
  mbox_lane #(.WIDTH(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_d2c (
    .prod_clk   (dbg_clk),
    .prod_rst_n (dbg_rst_ns),
    .prod_put   (dbg_put),
    .prod_data  (dbg_wdata),
    .prod_full  (dbg_r),
    .held_word  (d2c_word),
    .cons_clk   (core_clk),
    .cons_rst_n (core_rst_ns),
    .cons_take  (core_take),
    .cons_full  (core_r)
  );

  always_comb begin
    core_status             = {{PAD_W{1'b0}}, {STAT_FLAGS{1'b0}}};
    core_status[STAT_W_BIT] = core_w;
    core_status[STAT_R_BIT] = core_r;
    dbg_status              = {{PAD_W{1'b0}}, {STAT_FLAGS{1'b0}}};
    dbg_status[STAT_W_BIT]  = dbg_w;
    dbg_status[STAT_R_BIT]  = dbg_r;
  end

  always_comb begin
    core_rdata = (core_addr == SLOT_DATA) ? d2c_word : core_status;
    dbg_rdata  = (dbg_addr  == SLOT_DATA) ? c2d_word : dbg_status;
  end
endmodule

// File: rtl/dbg_mailbox_chk.sv
module dbg_mailbox_chk #(
  parameter int DATA_W = 32
) (
  input logic              core_clk,
  input logic              core_rst_ns,
  input logic              core_wr_en,
  input logic              core_rd_en,
  input logic              core_addr,
  input logic [DATA_W-1:0] core_rdata,
  input logic              core_w,
  input logic              core_r,
  input logic [DATA_W-1:0] c2d_word,
  input logic              dbg_clk,
  input logic              dbg_rst_ns,
  input logic              dbg_wr_en,
  input logic              dbg_rd_en,
  input logic              dbg_addr,
  input logic [DATA_W-1:0] dbg_rdata,
  input logic              dbg_w,
  input logic              dbg_r,
  input logic [DATA_W-1:0] d2c_word
);
  AST_CORE_SEND_SETS_W: assert property (@(posedge core_clk) disable iff (!core_rst_ns)
    (core_wr_en && core_addr && !core_w) |=> core_w); // R1

  AST_CORE_W_NEEDS_WRITE: assert property (@(posedge core_clk) disable iff (!core_rst_ns)
    (!core_w && !(core_wr_en && core_addr)) |=> !core_w); // R1

  AST_CORE_NO_OVERWRITE: assert property (@(posedge core_clk) disable iff (!core_rst_ns)
    (core_wr_en && core_addr && core_w) |=> $stable(c2d_word)); // R4

  AST_DBG_TAKE_CLEARS_W: assert property (@(posedge dbg_clk) disable iff (!dbg_rst_ns)
    (dbg_rd_en && dbg_addr && dbg_w) |=> !dbg_w); // R2

  AST_DBG_SEND_SETS_R: assert property (@(posedge dbg_clk) disable iff (!dbg_rst_ns)
    (dbg_wr_en && dbg_addr && !dbg_r) |=> dbg_r); // R5

  AST_DBG_NO_OVERWRITE: assert property (@(posedge dbg_clk) disable iff (!dbg_rst_ns)
    (dbg_wr_en && dbg_addr && dbg_r) |=> $stable(d2c_word)); // R8

  AST_CORE_TAKE_CLEARS_R: assert property (@(posedge core_clk) disable iff (!core_rst_ns)
    (core_rd_en && core_addr && core_r) |=> !core_r); // R6

  AST_CORE_STATUS_PAD: assert property (@(posedge core_clk) disable iff (!core_rst_ns)
    !core_addr |-> (core_rdata[DATA_W-1:2] == '0)); // R9

  AST_DBG_STATUS_PAD: assert property (@(posedge dbg_clk) disable iff (!dbg_rst_ns)
    !dbg_addr |-> (dbg_rdata[DATA_W-1:2] == '0)); // R9
endmodule

bind dbg_mailbox dbg_mailbox_chk #(.DATA_W(DATA_W)) u_chk (
  .core_clk    (core_clk),
  .core_rst_ns (core_rst_ns),
  .core_wr_en  (core_wr_en),
  .core_rd_en  (core_rd_en),
  .core_addr   (core_addr),
  .core_rdata  (core_rdata),
  .core_w      (core_w),
  .core_r      (core_r),
  .c2d_word    (c2d_word),
  .dbg_clk     (dbg_clk),
  .dbg_rst_ns  (dbg_rst_ns),
  .dbg_wr_en   (dbg_wr_en),
  .dbg_rd_en   (dbg_rd_en),
  .dbg_addr    (dbg_addr),
  .dbg_rdata   (dbg_rdata),
  .dbg_w       (dbg_w),
  .dbg_r       (dbg_r),
  .d2c_word    (d2c_word)
);

// File: tb/tb_dbg_mailbox.sv
`timescale 1ns/1ps
module tb_dbg_mailbox;
  localparam int DW   = 32;
  localparam int SYNC = 2;
  localparam int SEED = 1234;

  logic          core_clk = 1'b0, dbg_clk = 1'b0;
  logic          core_rst_n, dbg_rst_n;
  logic          core_wr_en, core_rd_en, core_addr;
  logic [DW-1:0] core_wdata, core_rdata;
  logic          dbg_wr_en, dbg_rd_en, dbg_addr;
  logic [DW-1:0] dbg_wdata, dbg_rdata;

  int n_total = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #4    core_clk = ~core_clk;   // 125 MHz
  always #11.5 dbg_clk  = ~dbg_clk;

  dbg_mailbox #(.DATA_W(DW), .SYNC_STAGES(SYNC)) dut (
    .core_clk(core_clk), .core_rst_n(core_rst_n), .core_wr_en(core_wr_en),
    .core_rd_en(core_rd_en), .core_addr(core_addr), .core_wdata(core_wdata),
    .core_rdata(core_rdata),
    .dbg_clk(dbg_clk), .dbg_rst_n(dbg_rst_n), .dbg_wr_en(dbg_wr_en),
    .dbg_rd_en(dbg_rd_en), .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata),
    .dbg_rdata(dbg_rdata)
  );

  function automatic logic [DW-1:0] exp_status(input logic w, input logic r);
    logic [DW-1:0] s;
    s = '0;
    s[0] = w;
    s[1] = r;
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic core_stat(output logic [DW-1:0] s);
    @(negedge core_clk);
    core_wr_en = 0; core_rd_en = 0; core_addr = 0;
    #1 s = core_rdata;
  endtask

  task automatic dbg_stat(output logic [DW-1:0] s);
    @(negedge dbg_clk);
    dbg_wr_en = 0; dbg_rd_en = 0; dbg_addr = 0;
    #1 s = dbg_rdata;
  endtask

  task automatic core_wr(input logic a, input logic [DW-1:0] d);
    @(negedge core_clk);
    core_addr = a; core_wdata = d; core_wr_en = 1; core_rd_en = 0;
    @(negedge core_clk);
    core_wr_en = 0; core_addr = 0;
  endtask

  task automatic dbg_wr(input logic a, input logic [DW-1:0] d);
    @(negedge dbg_clk);
    dbg_addr = a; dbg_wdata = d; dbg_wr_en = 1; dbg_rd_en = 0;
    @(negedge dbg_clk);
    dbg_wr_en = 0; dbg_addr = 0;
  endtask

  task automatic core_take(output logic [DW-1:0] d);
    @(negedge core_clk);
    core_addr = 1; core_rd_en = 1; core_wr_en = 0;
    #1 d = core_rdata;
    @(negedge core_clk);
    core_rd_en = 0; core_addr = 0;
  endtask

  task automatic dbg_take(output logic [DW-1:0] d);
    @(negedge dbg_clk);
    dbg_addr = 1; dbg_rd_en = 1; dbg_wr_en = 0;
    #1 d = dbg_rdata;
    @(negedge dbg_clk);
    dbg_rd_en = 0; dbg_addr = 0;
  endtask

  // poll a status bit for a value; ok=1 if reached within max polls
  task automatic core_wait(input int bitn, input logic val, input int max, output bit ok);
    logic [DW-1:0] s;
    ok = 0;
    for (int i = 0; i < max && !ok; i++) begin
      core_stat(s);
      if (s[bitn] == val) ok = 1;
    end
  endtask

  task automatic dbg_wait(input int bitn, input logic val, input int max, output bit ok);
    logic [DW-1:0] s;
    ok = 0;
    for (int i = 0; i < max && !ok; i++) begin
      dbg_stat(s);
      if (s[bitn] == val) ok = 1;
    end
  endtask

  // full protocol transfers used by the random phase
  task automatic send_up(input logic [DW-1:0] d);
    logic [DW-1:0] got;
    bit ok;
    core_wait(0, 1'b0, 20, ok);
    check(ok, "R3 W clear before send", {31'b0, ok}, 1);
    core_wr(1, d);
    if ($urandom_range(0, 2) == 0) core_wr(1, ~d);   // overwrite attempt
    dbg_wait(0, 1'b1, SYNC + 3, ok);
    check(ok, "R2 W seen by debugger", {31'b0, ok}, 1);
    dbg_take(got);
    check(got == d, "R2/R4 debugger word", got, d);
  endtask

  task automatic send_down(input logic [DW-1:0] d);
    logic [DW-1:0] got;
    bit ok;
    dbg_wait(1, 1'b0, 20, ok);
    check(ok, "R7 R clear before send", {31'b0, ok}, 1);
    dbg_wr(1, d);
    if ($urandom_range(0, 2) == 0) dbg_wr(1, d ^ 32'h5a5a_0f0f);
    core_wait(1, 1'b1, SYNC + 3, ok);
    check(ok, "R6 R seen by core", {31'b0, ok}, 1);
    core_take(got);
    check(got == d, "R6/R8 core word", got, d);
  endtask

  initial begin
    #1600000;
    if (!finished) begin
      n_total++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] s, got;
    bit ok;
    void'($urandom(SEED));
    core_rst_n = 0; dbg_rst_n = 0;
    core_wr_en = 0; core_rd_en = 0; core_addr = 0; core_wdata = '0;
    dbg_wr_en = 0; dbg_rd_en = 0; dbg_addr = 0; dbg_wdata = '0;
    repeat (6) @(negedge dbg_clk);
    core_rst_n = 1; dbg_rst_n = 1;
    repeat (6) @(negedge dbg_clk);

    // R10: reset state
    core_stat(s); check(s == exp_status(0, 0), "R10 core status", s, exp_status(0, 0));
    dbg_stat(s);  check(s == exp_status(0, 0), "R10 dbg status", s, exp_status(0, 0));

    // R9: status slot writes ignored on both sides
    core_wr(0, '1);
    dbg_wr(0, '1);
    repeat (8) @(negedge dbg_clk);
    core_stat(s); check(s == exp_status(0, 0), "R9 core status write", s, exp_status(0, 0));
    dbg_stat(s);  check(s == exp_status(0, 0), "R9 dbg status write", s, exp_status(0, 0));

    // R11: data reads while empty do not move flags
    core_take(got);
    dbg_take(got);
    repeat (8) @(negedge dbg_clk);
    core_stat(s); check(s == exp_status(0, 0), "R11 core flags", s, exp_status(0, 0));
    dbg_stat(s);  check(s == exp_status(0, 0), "R11 dbg flags", s, exp_status(0, 0));

    // R1..R4: core to debugger, with an overwrite attempt
    core_wr(1, 32'hcafe_0001);
    #1 core_addr = 0;
    #1 check(core_rdata == exp_status(1, 0), "R1 W next cycle", core_rdata, exp_status(1, 0));
    core_wr(1, 32'hdead_beef);
    dbg_wait(0, 1'b1, SYNC + 3, ok);
    check(ok, "R2 W synchronized", {31'b0, ok}, 1);
    core_stat(s); check(s == exp_status(1, 0), "R3 W held until read", s, exp_status(1, 0));
    dbg_take(got);
    check(got == 32'hcafe_0001, "R4 first word kept", got, 32'hcafe_0001);
    #1 check(dbg_rdata == exp_status(0, 0), "R2 W clear on debugger", dbg_rdata, exp_status(0, 0));
    core_wait(0, 1'b0, SYNC + 3, ok);
    check(ok, "R3 W clear on core", {31'b0, ok}, 1);

    // R5..R8: debugger to core, with an overwrite attempt
    dbg_wr(1, 32'h1234_5678);
    #1 dbg_addr = 0;
    #1 check(dbg_rdata == exp_status(0, 1), "R5 R next cycle", dbg_rdata, exp_status(0, 1));
    dbg_wr(1, 32'h0bad_f00d);
    core_wait(1, 1'b1, SYNC + 3, ok);
    check(ok, "R6 R synchronized", {31'b0, ok}, 1);
    core_take(got);
    check(got == 32'h1234_5678, "R8 first word kept", got, 32'h1234_5678);
    #1 check(core_rdata == exp_status(0, 0), "R6 R clear on core", core_rdata, exp_status(0, 0));
    dbg_wait(1, 1'b0, SYNC + 3, ok);
    check(ok, "R7 R clear on debugger", {31'b0, ok}, 1);

    // R9: both flags set at once, bit positions on both sides
    core_wr(1, 32'h0000_00a5);
    dbg_wr(1, 32'h0000_005a);
    repeat (6) @(negedge dbg_clk);
    core_stat(s); check(s == exp_status(1, 1), "R9 core both flags", s, exp_status(1, 1));
    dbg_stat(s);  check(s == exp_status(1, 1), "R9 dbg both flags", s, exp_status(1, 1));
    dbg_take(got);  check(got == 32'h0000_00a5, "R2 drain up", got, 32'h0000_00a5);
    core_take(got); check(got == 32'h0000_005a, "R6 drain down", got, 32'h0000_005a);

    // random traffic in both directions
    for (int i = 0; i < 40; i++) begin
      if ($urandom_range(0, 1) == 0) send_up($urandom());
      else                           send_down($urandom());
    end

    repeat (8) @(negedge dbg_clk);
    core_stat(s); check(s == exp_status(0, 0), "R3/R6 core idle at end", s, exp_status(0, 0));
    dbg_stat(s);  check(s == exp_status(0, 0), "R2/R7 dbg idle at end", s, exp_status(0, 0));

    finished = 1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule